// File: doc/BRIEF.md
# Indexed Absolute Address Bus Sequencer

This block runs the bus side of one absolute-indexed memory instruction for an 8-bit processor. A start pulse hands it the program counter, the index register value, the operation kind (load or store) and, for a store, the byte to be written. It then drives one memory access per clock on a 16-bit address bus. First it fetches the opcode and the two operand bytes. Next it adds the index to the low operand byte in an 8-bit adder, while the high operand byte is still on the bus. Last it issues the data access.

The first data access always goes to the partially added address, with the high byte not yet carried. A load with no carry out of the low byte ends there. A load that carries spends one more cycle: the same 8-bit adder increments the high byte, and the read is repeated at the correct address. A store always spends that extra cycle. It performs a dummy read at the uncarried address and then writes at the carried address. A separate 16-bit incrementer advances the program counter. The loaded byte and a one-clock done pulse come out at the end.

Top module: `idx_abs_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, rd_o, wr_o and done_o are low.
- R2: The first three bus cycles after start are reads at pc, pc+1 and pc+2, taken modulo 65536; they return the opcode, the low operand byte and the high operand byte.
- R3: The fourth bus cycle is always a read at {high byte, (low byte + index) mod 256}, with no carry into the high byte.
- R4: A load whose low byte plus index is below 256 uses exactly 4 bus cycles, and load_data_o takes the byte returned by the fourth read.
- R5: A load whose low byte plus index is 256 or more uses a fifth read at the fully carried address, and load_data_o takes that fifth byte.
- R6: A store always uses 5 bus cycles: the fourth is a dummy read and the fifth is a write of the captured store byte at the fully carried address, whether or not a carry occurred.
- R7: In every cycle of a running sequence exactly one of rd_o and wr_o is high.
- R8: done_o is high for exactly one clock, in the cycle right after the final access.
- R9: The carried effective address wraps modulo 65536 when {high, low} + index passes 0xFFFF.
- R10: A start pulse that arrives while a sequence is running is ignored, and the running sequence keeps its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| pc_i | input | 16 | Address of the opcode |
| index_i | input | 8 | Index register value |
| is_store_i | input | 1 | 1 = store, 0 = load |
| wdata_i | input | 8 | Byte to store |
| rdata_i | input | 8 | Read data from memory (valid in the same cycle) |
| addr_o | output | 16 | Bus address |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| wdata_o | output | 8 | Write data |
| load_data_o | output | 8 | Byte returned by a load |
| done_o | output | 1 | One-clock pulse after the last access |

## Verification
The bench aims at index sums that land just below and just above 256, because a design that applied the carry early would skip the dummy read, and one that ignored the carry would load from the wrong page. It runs stores with a zero carry, since a design that treated stores like loads would drop the dummy read or write one cycle early. It places operands at 0xFFFF so that both the program counter and the effective address wrap; a wrong width there would send the access to a nonexistent upper address. It also pulses start in the middle of a sequence, which would make a careless design reload its operands in the middle of the access.

// File: rtl/idx_abs_pkg.sv
package idx_abs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_LO,
    ST_HI,
    ST_PART,
    ST_FIX
  } seq_state_e;
endpackage

// File: rtl/idx_abs_alu8.sv
module idx_abs_alu8 #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
endmodule

// File: rtl/idx_abs_pc_inc.sv
module idx_abs_pc_inc #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] pc_o
);
  assign pc_o = pc_i + {{(ADDR_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/idx_abs_seq.sv
module idx_abs_seq #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] index_i,
  input  logic              is_store_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              done_o
);
  import idx_abs_pkg::*;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] pc_q, pc_nxt;
  logic [DATA_W-1:0] idx_q, wd_q, lo_q, hi_q, load_q;
  logic              store_q, carry_q, done_q;

  logic [DATA_W-1:0] alu_a, alu_b, alu_sum;
  logic              alu_cin, alu_cout;

  // shared 8-bit adder: low byte + index in ST_HI, high byte + carry in ST_PART
  always_comb begin
    if (state_q == ST_HI) begin
      alu_a   = lo_q;
      alu_b   = idx_q;
      alu_cin = 1'b0;
    end else begin
      alu_a   = hi_q;
      alu_b   = '0;
      alu_cin = carry_q;
    end
  end

  idx_abs_alu8 #(.DATA_W(DATA_W)) u_alu (
    .a_i   (alu_a),
    .b_i   (alu_b),
    .cin_i (alu_cin),
    .sum_o (alu_sum),
    .cout_o(alu_cout)
  );

  idx_abs_pc_inc #(.ADDR_W(ADDR_W)) u_pc_inc (
    .pc_i(pc_q),
    .pc_o(pc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      idx_q   <= '0;
      wd_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      load_q  <= '0;
      store_q <= 1'b0;
      carry_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pc_q    <= pc_i;
          idx_q   <= index_i;
          store_q <= is_store_i;
          wd_q    <= wdata_i;
          state_q <= ST_OPC;
        end
        ST_OPC: begin
          pc_q    <= pc_nxt;
          state_q <= ST_LO;
        end
        ST_LO: begin
          lo_q    <= rdata_i;
          pc_q    <= pc_nxt;
          state_q <= ST_HI;
        end
        ST_HI: begin
          hi_q    <= rdata_i;
          lo_q    <= alu_sum;
          carry_q <= alu_cout;
          state_q <= ST_PART;
        end
        ST_PART: begin
          if (store_q || carry_q) begin
            hi_q    <= alu_sum;
            state_q <= ST_FIX;
          end else begin
            load_q  <= rdata_i;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_FIX: begin
          if (!store_q) load_q <= rdata_i;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    addr_o = pc_q;
    rd_o   = 1'b0;
    wr_o   = 1'b0;
    unique case (state_q)
      ST_OPC, ST_LO, ST_HI: rd_o = 1'b1;
      ST_PART: begin
        addr_o = {hi_q, lo_q};
        rd_o   = 1'b1;
      end
      ST_FIX: begin
        addr_o = {hi_q, lo_q};
        rd_o   = !store_q;
        wr_o   = store_q;
      end
      default: ;
    endcase
  end

  assign wdata_o     = wd_q;
  assign load_data_o = load_q;
  assign done_o      = done_q;
endmodule

// File: rtl/idx_abs_seq_chk.sv
module idx_abs_seq_chk
  import idx_abs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input seq_state_e        state_q,
  input logic              store_q,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rd_o,
  input logic              wr_o,
  input logic              done_o
);
  // R7
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (rd_o ^ wr_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!rd_o && !wr_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_after_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rd_o || wr_o));

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LO || state_q == ST_HI) |-> (addr_o == $past(addr_o) + 1'b1));

  // R6
  store_dummy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ($past(rd_o) && store_q));

  // R5
  fix_low_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIX) |-> (addr_o[7:0] == $past(addr_o[7:0])));
endmodule

bind idx_abs_seq idx_abs_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .state_q(state_q),
  .store_q(store_q),
  .addr_o (addr_o),
  .rd_o   (rd_o),
  .wr_o   (wr_o),
  .done_o (done_o)
);

// File: tb/idx_abs_seq_tb.sv
module idx_abs_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  index_i = '0;
  logic        is_store_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_i;
  logic [15:0] addr_o;
  logic        rd_o, wr_o, done_o;
  logic [7:0]  wdata_o, load_data_o;

  logic [15:0] cur_pc = '0;
  logic [7:0]  cur_lo = '0, cur_hi = '0;
  int checks = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  function automatic logic [7:0] mem_at(input logic [15:0] a, input logic [15:0] p,
                                        input logic [7:0] lo, input logic [7:0] hi);
    if (a == p) return 8'hBD;
    if (a == p + 16'd1) return lo;
    if (a == p + 16'd2) return hi;
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign rdata_i = mem_at(addr_o, cur_pc, cur_lo, cur_hi);

  idx_abs_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pc_i(pc_i),
    .index_i(index_i), .is_store_i(is_store_i), .wdata_i(wdata_i),
    .rdata_i(rdata_i), .addr_o(addr_o), .rd_o(rd_o), .wr_o(wr_o),
    .wdata_o(wdata_o), .load_data_o(load_data_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 1 = read, 2 = write
  task automatic run(input logic [15:0] pc, input logic [7:0] idx, input logic [7:0] lo,
                     input logic [7:0] hi, input bit st, input logic [7:0] wd,
                     input bit poke);
    logic [15:0] e_addr[5];
    int          e_kind[5];
    int          n_exp;
    logic [15:0] full;
    logic [8:0]  lsum;
    logic [7:0]  e_load;
    int          n;
    bit          seen_done;
    lsum = {1'b0, lo} + {1'b0, idx};
    full = {hi, lo} + {8'h00, idx};
    e_addr[0] = pc; e_addr[1] = pc + 16'd1; e_addr[2] = pc + 16'd2;
    e_addr[3] = {hi, lsum[7:0]};
    e_addr[4] = full;
    for (int i = 0; i < 5; i++) e_kind[i] = 1;
    if (st) begin
      e_kind[4] = 2;
      n_exp = 5;
    end else n_exp = lsum[8] ? 5 : 4;
    e_load = mem_at(e_addr[n_exp-1], pc, lo, hi);
    @(negedge clk_i);
    cur_pc = pc; cur_lo = lo; cur_hi = hi;
    pc_i = pc; index_i = idx; is_store_i = st; wdata_i = wd; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    seen_done = 0;
    for (int c = 0; c < 10 && !seen_done; c++) begin
      if (poke && c == 1) begin
        // R10: a start while busy must not disturb the sequence
        pc_i = ~pc; index_i = ~idx; is_store_i = ~st; wdata_i = ~wd; start_i = 1'b1;
      end
      if (done_o) begin
        seen_done = 1;
        chk(!rd_o && !wr_o, "R8 no access in done cycle", {rd_o, wr_o}, 0);
      end else begin
        chk(rd_o ^ wr_o, "R7 one strobe", {wr_o, rd_o}, 1);
        if (n < 5) begin
          chk(addr_o == e_addr[n], n < 3 ? "R2 fetch addr" : (n == 3 ? "R3 partial addr" : "R5/R6/R9 carried addr"),
              addr_o, e_addr[n]);
          chk(int'({wr_o, rd_o}) == e_kind[n], st ? "R6 strobe kind" : "R4/R5 strobe kind",
              {wr_o, rd_o}, e_kind[n]);
          if (wr_o) chk(wdata_o == wd, "R6 write data", wdata_o, wd);
        end
        n++;
      end
      @(negedge clk_i);
      start_i = 1'b0;
    end
    chk(seen_done, "R8 done seen", seen_done, 1);
    chk(n == n_exp, st ? "R6 cycle count" : (n_exp == 4 ? "R4 cycle count" : "R5 cycle count"), n, n_exp);
    if (!st && seen_done) chk(load_data_o == e_load, n_exp == 4 ? "R4 load data" : "R5 load data",
                              load_data_o, e_load);
    chk(!done_o && !rd_o && !wr_o, "R8/R1 single pulse then idle", {done_o, wr_o, rd_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(!rd_o && !wr_o && !done_o, "R1 reset state", {done_o, wr_o, rd_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!rd_o && !wr_o && !done_o, "R1 idle after reset", {done_o, wr_o, rd_o}, 0);
    run(16'h8000, 8'h10, 8'h34, 8'h12, 1'b0, 8'h00, 1'b0); // R4 no carry
    run(16'h8003, 8'hF0, 8'h34, 8'h12, 1'b0, 8'h00, 1'b0); // R5 carry
    run(16'h8006, 8'h00, 8'hFF, 8'h20, 1'b0, 8'h00, 1'b0); // R4 index zero
    run(16'h8009, 8'h01, 8'hFF, 8'h20, 1'b0, 8'h00, 1'b0); // R5 sum exactly 256
    run(16'h9000, 8'h15, 8'h00, 8'h40, 1'b1, 8'h5C, 1'b0); // R6 store no carry
    run(16'h9003, 8'h80, 8'h90, 8'h40, 1'b1, 8'hC3, 1'b0); // R6 store carry
    run(16'hFFFE, 8'h20, 8'hF0, 8'hFF, 1'b0, 8'h00, 1'b0); // R9 wrap, R2 pc wrap
    run(16'hFFFF, 8'hFF, 8'hFF, 8'hFF, 1'b1, 8'h77, 1'b0); // R9 store wrap
    run(16'hA000, 8'hC0, 8'h70, 8'h33, 1'b0, 8'h00, 1'b1); // R10
    run(16'hA100, 8'h05, 8'h10, 8'h33, 1'b1, 8'h99, 1'b1); // R10
    for (int k = 0; k < 60; k++) begin
      run(16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
          1'($urandom), 8'($urandom), 1'($urandom_range(0, 3) == 0));
      repeat ($urandom_range(0, 2)) @(negedge clk_i);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule